// File: doc/BRIEF.md
# Register and Packet-Buffer Access Slave on a Two-Wire Serial Bus

This block lets an external host reach a small byte-wide register space and two packet byte queues over a two-wire serial bus. It runs entirely on the system clock. The clock and data lines are synchronised and oversampled, and bus START, STOP, rising-clock and falling-clock events are derived from them. The data line is driven only through an open-drain style output enable. A 7-bit device address is matched against a fixed upper nibble and three strap inputs. In a write transaction, the first byte after the address selects a register and the following bytes are stored there. A read transaction always begins at the register named by a writable read-pointer register.

Two queues sit behind single register addresses. Bytes the host writes to the transmit port are queued for the radio side. That side drains them through a pop strobe. Bytes the radio side pushes are drained by the host reading the receive port. A control register rewinds either pointer of either queue without touching the stored bytes. Four event pulses from the radio side set sticky status flags. An enable register gates these flags onto an active-low interrupt output, and reading the status register clears it.

Top module: `i2c_fifo_regslave`

## Requirements
- R1: The device acknowledges only the address byte whose upper 7 bits equal binary 0110 followed by strap_i[2:0]. Any other address is not acknowledged, and SDA stays released until the next START.
- R2: In a write, the byte after the address is the register index. Each further byte is written to the current index, which then advances by one, except at index 0x01 and 0x02, where it stays fixed.
- R3: A read transaction returns bytes starting at the index held in register 0x00 (reset 0x00), advancing by the same rule as R2. Reading never alters register 0x00.
- R4: Writing index 0x02 appends the byte to the transmit queue and is acknowledged. When the queue is full, the byte is answered with NACK and discarded. The radio side sees the oldest byte on tx_data_o and removes it with tx_pop_i. A pop on an empty queue is ignored.
- R5: Reading index 0x01 returns and removes the oldest receive-queue byte. If the queue is empty, the read returns 0x00 and removes nothing. rx_push_i appends rx_data_i, and it is ignored while rx_full_o is high.
- R6: Writing index 0x03 sets queue pointers to zero without erasing data. The code in bits [2:0] selects which pointers: 001 receive read, 010 receive write, 011 transmit read, 100 transmit write, 111 all four. Other codes reset nothing. Bits [2:0] read back, and the upper bits read as 0.
- R7: Index 0x04 holds the interrupt enables in bits [3:0]. Its reset value is 0x08, and the upper bits read as 0.
- R8: Status bit i (index 0x05, bits [3:0]) becomes 1 one cycle after a pulse on evt_i[i] and stays set until a host read of index 0x05. That read returns the flags and clears them, but an event in the clearing cycle is kept.
- R9: irq_n is low exactly while some status bit and its enable bit are both 1.
- R10: Index 0x7E reads 0xB1. Unlisted indices read 0x00 and ignore writes.
- R11: A repeated START restarts address matching. A STOP returns the slave to idle with SDA released.
- R12: After reset, SDA is released, irq_n is high and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Low three bits of the device address |
| evt_i | input | 4 | Event pulses: 0 transmit done, 1 packet received, 2 channel-assessment ready, 3 command ready |
| irq_n | output | 1 | Active-low interrupt request |
| tx_pop_i | input | 1 | Remove oldest transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Append rx_data_i to receive queue |
| rx_data_i | input | 8 | Byte to append |
| rx_full_o | output | 1 | Receive queue full |

## Verification
Several properties are checked on every cycle. A full transmit queue must lead to a released data line in the acknowledge slot. A foreign address must leave the line released. A STOP must return the engine to idle, and register 0x00 must stay still while bytes are shifted out. The queues must never push while full or pop while empty, and flags must stick until cleared. End-to-end behaviour can only be shown by the bench's bus transactions. This covers pointer rewinds that replay stored bytes, the index walk in bursts, clear-on-read of the status register, the interrupt gating, and the order of queue data.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RECV,
        BS_ACK,
        BS_SEND,
        BS_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_SUB,
        BK_DATA
    } byte_kind_e;

    // Register indices
    localparam logic [7:0] RA_RDPTR  = 8'h00;
    localparam logic [7:0] RA_RXPORT = 8'h01;
    localparam logic [7:0] RA_TXPORT = 8'h02;
    localparam logic [7:0] RA_FCTL   = 8'h03;
    localparam logic [7:0] RA_IMASK  = 8'h04;
    localparam logic [7:0] RA_ISTAT  = 8'h05;
    localparam logic [7:0] RA_IDENT  = 8'h7E;

    // Fixed upper part of the 7-bit device address
    localparam logic [3:0] ADDR_HI = 4'b0110;

    localparam int N_EVT = 4;

    // Pointer rewind codes
    localparam logic [2:0] FC_RX_RD = 3'b001;
    localparam logic [2:0] FC_RX_WR = 3'b010;
    localparam logic [2:0] FC_TX_RD = 3'b011;
    localparam logic [2:0] FC_TX_WR = 3'b100;
    localparam logic [2:0] FC_ALL   = 3'b111;

    typedef struct packed {
        logic rx_rd;
        logic rx_wr;
        logic tx_rd;
        logic tx_wr;
    } ptr_clr_t;

endpackage

// File: rtl/ifr_pin_sync.sv
module ifr_pin_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    typedef struct packed {
        logic [SYNC_LEN-1:0] scl_sh;
        logic [SYNC_LEN-1:0] sda_sh;
        logic                scl_prev;
        logic                sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[SYNC_LEN-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[SYNC_LEN-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_sh[SYNC_LEN-1];
        sync_d.sda_prev = sync_q.sda_sh[SYNC_LEN-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_sh[SYNC_LEN-1];
    assign sda_s     = sync_q.sda_sh[SYNC_LEN-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign bus_start = scl_s & sync_q.scl_prev & ~sda_s & sync_q.sda_prev;
    assign bus_stop  = scl_s & sync_q.scl_prev & sda_s & ~sync_q.sda_prev;

endmodule

// File: rtl/ifr_fifo.sv
module ifr_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty,
    input  logic          clr_rd,
    input  logic          clr_wr
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] fill;

    assign fill  = ptr_q.wptr - ptr_q.rptr;
    assign full  = fill[AW];
    assign empty = (fill == '0);
    assign rdata = mem[ptr_q.rptr[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (clr_wr)    ptr_d.wptr = '0;
        else if (push) ptr_d.wptr = ptr_q.wptr + 1'b1;
        if (clr_rd)    ptr_d.rptr = '0;
        else if (pop)  ptr_d.rptr = ptr_q.rptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q.wptr[AW-1:0]] <= wdata;
    end

    // R4: the owner never appends to a full queue
    p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5: the owner never removes from an empty queue
    p_pop_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/ifr_irq_ctl.sv
module ifr_irq_ctl #(
    parameter int           N        = 4,
    parameter logic [N-1:0] MASK_RST = 4'b1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    input  logic         stat_clr,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] stat_o,
    output logic         irq_n
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] stat;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.stat = (irq_q.stat & ~{N{stat_clr}}) | evt;
        if (mask_we) irq_d.mask = mask_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q.mask <= MASK_RST;
            irq_q.stat <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign mask_o = irq_q.mask;
    assign stat_o = irq_q.stat;
    assign irq_n  = ~|(irq_q.stat & irq_q.mask);

    // R8: every pulsed event is recorded on the next cycle
    p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_o & $past(evt)) == $past(evt)));

    // R8: flags are sticky unless cleared by a status read
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

endmodule

// File: rtl/i2c_fifo_regslave.sv
module i2c_fifo_regslave
    import ifr_pkg::*;
#(
    parameter int         DEPTH     = 8,
    parameter int         SYNC_LEN  = 2,
    parameter logic [7:0] CHIP_ID   = 8'hB1,
    parameter logic [3:0] IMASK_RST = 4'b1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic [3:0] evt_i,
    output logic       irq_n,
    input  logic       tx_pop_i,
    output logic [7:0] tx_data_o,
    output logic       tx_empty_o,
    input  logic       rx_push_i,
    input  logic [7:0] rx_data_i,
    output logic       rx_full_o
);

    localparam int BITS = 8;
    localparam logic [3:0] LAST_BIT = 4'(BITS);

    typedef struct packed {
        bus_st_e    st;
        byte_kind_e kind;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic       rw;
        logic       nack;
        logic       sda_oe;
        logic [7:0] cursor;
        logic [7:0] rdptr;
        logic [2:0] fctl;
    } core_t;

    core_t core_d, core_q;

    logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic       tx_push, tx_full, tx_pop_ok;
    logic       rx_pop, rx_empty, rx_push_ok;
    logic [7:0] rx_head;
    logic       mask_we, stat_clr, do_load, accept;
    logic [3:0] imask, istat;
    logic [7:0] rd_byte;
    logic       addr_hit;
    ptr_clr_t   pclr;

    function automatic logic [7:0] next_cursor(input logic [7:0] c);
        if (c == RA_RXPORT || c == RA_TXPORT) return c;
        return c + 8'd1;
    endfunction

    ifr_pin_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    assign tx_pop_ok  = tx_pop_i & ~tx_empty_o;
    assign rx_push_ok = rx_push_i & ~rx_full_o;

    ifr_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (tx_push),
        .wdata  (core_q.shreg),
        .pop    (tx_pop_ok),
        .rdata  (tx_data_o),
        .full   (tx_full),
        .empty  (tx_empty_o),
        .clr_rd (pclr.tx_rd),
        .clr_wr (pclr.tx_wr)
    );

    ifr_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rx_push_ok),
        .wdata  (rx_data_i),
        .pop    (rx_pop),
        .rdata  (rx_head),
        .full   (rx_full_o),
        .empty  (rx_empty),
        .clr_rd (pclr.rx_rd),
        .clr_wr (pclr.rx_wr)
    );

    ifr_irq_ctl #(.N(N_EVT), .MASK_RST(IMASK_RST)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .mask_we  (mask_we),
        .mask_wd  (core_q.shreg[3:0]),
        .stat_clr (stat_clr),
        .mask_o   (imask),
        .stat_o   (istat),
        .irq_n    (irq_n)
    );

    assign addr_hit = (core_q.shreg[7:1] == {ADDR_HI, strap_i});

    // Register read multiplexer, indexed by the running cursor
    always_comb begin
        case (core_q.cursor)
            RA_RDPTR:  rd_byte = core_q.rdptr;
            RA_RXPORT: rd_byte = rx_empty ? 8'h00 : rx_head;
            RA_FCTL:   rd_byte = {5'b0, core_q.fctl};
            RA_IMASK:  rd_byte = {4'b0, imask};
            RA_ISTAT:  rd_byte = {4'b0, istat};
            RA_IDENT:  rd_byte = CHIP_ID;
            default:   rd_byte = 8'h00;
        endcase
    end

    always_comb begin
        core_d   = core_q;
        tx_push  = 1'b0;
        rx_pop   = 1'b0;
        mask_we  = 1'b0;
        stat_clr = 1'b0;
        do_load  = 1'b0;
        accept   = 1'b1;
        pclr     = '0;

        if (bus_stop) begin
            core_d.st     = BS_IDLE;
            core_d.sda_oe = 1'b0;
        end else if (bus_start) begin
            core_d.st     = BS_RECV;
            core_d.kind   = BK_ADDR;
            core_d.bitcnt = '0;
            core_d.sda_oe = 1'b0;
        end else begin
            case (core_q.st)
                BS_RECV: begin
                    if (scl_rise) begin
                        core_d.shreg  = {core_q.shreg[6:0], sda_s};
                        core_d.bitcnt = core_q.bitcnt + 4'd1;
                    end else if (scl_fall && core_q.bitcnt == LAST_BIT) begin
                        core_d.bitcnt = '0;
                        case (core_q.kind)
                            BK_ADDR: begin
                                if (addr_hit) begin
                                    core_d.st     = BS_ACK;
                                    core_d.sda_oe = 1'b1;
                                    core_d.rw     = core_q.shreg[0];
                                    core_d.kind   = BK_SUB;
                                    core_d.cursor = core_q.rdptr;
                                end else begin
                                    core_d.st = BS_IDLE;
                                end
                            end
                            BK_SUB: begin
                                core_d.cursor = core_q.shreg;
                                core_d.kind   = BK_DATA;
                                core_d.st     = BS_ACK;
                                core_d.sda_oe = 1'b1;
                            end
                            default: begin
                                case (core_q.cursor)
                                    RA_RDPTR: core_d.rdptr = core_q.shreg;
                                    RA_TXPORT: begin
                                        if (tx_full) accept  = 1'b0;
                                        else         tx_push = 1'b1;
                                    end
                                    RA_FCTL: begin
                                        core_d.fctl = core_q.shreg[2:0];
                                        case (core_q.shreg[2:0])
                                            FC_RX_RD: pclr.rx_rd = 1'b1;
                                            FC_RX_WR: pclr.rx_wr = 1'b1;
                                            FC_TX_RD: pclr.tx_rd = 1'b1;
                                            FC_TX_WR: pclr.tx_wr = 1'b1;
                                            FC_ALL:   pclr       = '1;
                                            default:  pclr       = '0;
                                        endcase
                                    end
                                    RA_IMASK: mask_we = 1'b1;
                                    default:  ;
                                endcase
                                core_d.st     = BS_ACK;
                                core_d.sda_oe = accept;
                                core_d.cursor = next_cursor(core_q.cursor);
                            end
                        endcase
                    end
                end
                BS_ACK: begin
                    if (scl_fall) begin
                        core_d.sda_oe = 1'b0;
                        if (core_q.rw && core_q.kind == BK_SUB) begin
                            do_load = 1'b1;
                        end else begin
                            core_d.st     = BS_RECV;
                            core_d.bitcnt = '0;
                        end
                    end
                end
                BS_SEND: begin
                    if (scl_fall) begin
                        if (core_q.bitcnt == LAST_BIT) begin
                            core_d.sda_oe = 1'b0;
                            core_d.st     = BS_MACK;
                        end else begin
                            core_d.sda_oe = ~core_q.shreg[6];
                            core_d.shreg  = {core_q.shreg[6:0], 1'b0};
                            core_d.bitcnt = core_q.bitcnt + 4'd1;
                        end
                    end
                end
                BS_MACK: begin
                    if (scl_rise) begin
                        core_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (core_q.nack) core_d.st = BS_IDLE;
                        else             do_load   = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // Fetch the next byte to shift out and apply read side effects
        if (do_load) begin
            core_d.st     = BS_SEND;
            core_d.shreg  = rd_byte;
            core_d.sda_oe = ~rd_byte[7];
            core_d.bitcnt = 4'd1;
            core_d.cursor = next_cursor(core_q.cursor);
            if (core_q.cursor == RA_RXPORT && !rx_empty) rx_pop   = 1'b1;
            if (core_q.cursor == RA_ISTAT)               stat_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q        <= '0;
            core_q.st     <= BS_IDLE;
            core_q.kind   <= BK_ADDR;
            core_q.rdptr  <= RA_RDPTR;
        end else begin
            core_q <= core_d;
        end
    end

    assign sda_oe = core_q.sda_oe;

    // R4: a byte for a full transmit queue gets a released acknowledge slot
    p_nack_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == BS_RECV && core_q.kind == BK_DATA && core_q.cursor == RA_TXPORT
         && scl_fall && !bus_start && !bus_stop && core_q.bitcnt == LAST_BIT && tx_full)
        |=> !sda_oe);

    // R1: a foreign address never pulls the data line
    p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == BS_RECV && core_q.kind == BK_ADDR && scl_fall && !bus_start
         && !bus_stop && core_q.bitcnt == LAST_BIT && !addr_hit)
        |=> (!sda_oe && core_q.st == BS_IDLE));

    // R11: a STOP always returns to idle with the line released
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (core_q.st == BS_IDLE && !sda_oe));

    // R3: the read pointer register is untouched while bytes go out
    p_rdptr_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == BS_SEND || core_q.st == BS_MACK) |=> $stable(core_q.rdptr));

endmodule

// File: tb/i2c_fifo_regslave_tb_top.sv
module i2c_fifo_regslave_tb_top;
    import ifr_pkg::*;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 4;
    localparam int         DEPTH      = 8;
    localparam logic [2:0] STRAP      = 3'b010;
    localparam logic [7:0] DEV_W      = {ADDR_HI, STRAP, 1'b0};
    localparam logic [7:0] DEV_R      = {ADDR_HI, STRAP, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [3:0] evt = '0;
    logic       tx_pop = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;

    wire        sda_oe;
    wire        irq_n;
    wire        tx_empty;
    wire        rx_full;
    wire  [7:0] tx_data;
    wire        sda_line = sda_drv & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] model [32];
    logic [7:0] rbuf  [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_fifo_regslave #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .strap_i    (STRAP),
        .evt_i      (evt),
        .irq_n      (irq_n),
        .tx_pop_i   (tx_pop),
        .tx_data_o  (tx_data),
        .tx_empty_o (tx_empty),
        .rx_push_i  (rx_push),
        .rx_data_i  (rx_data),
        .rx_full_o  (rx_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qw();
        scl = 1'b1;     qw();
        sda_drv = 1'b0; qw();
        scl = 1'b0;     qw();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qw();
        scl = 1'b1;     qw();
        sda_drv = 1'b1; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; qw();
            scl = 1'b1; qw(); qw();
            scl = 1'b0; qw();
        end
        sda_drv = 1'b1; qw();
        scl = 1'b1; qw();
        nak = sda_line; qw();
        scl = 1'b0; qw();
    endtask

    task automatic rbyte(input logic last, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl = 1'b1; qw();
            b[i] = sda_line; qw();
            scl = 1'b0; qw();
        end
        sda_drv = last; qw();
        scl = 1'b1; qw(); qw();
        scl = 1'b0; qw();
        sda_drv = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        logic n;
        bus_start(); wbyte(DEV_W, n); wbyte(a, n); wbyte(v, n); bus_stop();
    endtask

    task automatic rd_raw(input int n);
        logic k;
        bus_start(); wbyte(DEV_R, k);
        for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] a, input int n);
        wr_reg(RA_RDPTR, a);
        rd_raw(n);
    endtask

    task automatic modem_push(input logic [7:0] v);
        rx_data = v; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic modem_pop();
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        evt = e;
        @(negedge clk); evt = '0;
        repeat (3) @(negedge clk);
    endtask

    // Expected enable-register value from a written byte (R7)
    function automatic logic [7:0] mask_of(input logic [7:0] v);
        return {4'b0, v[3:0]};
    endfunction

    task automatic tx_burst_check(input int n, input string tag);
        logic k;
        bus_start(); wbyte(DEV_W, k); wbyte(RA_TXPORT, k);
        for (int i = 0; i < n; i++) begin
            model[i] = 8'($urandom);
            wbyte(model[i], k);
            chk({tag, " tx ack"}, int'(k), 0);
        end
        bus_stop();
        for (int i = 0; i < n; i++) begin
            chk({tag, " tx order"}, int'(tx_data), int'(model[i]));
            modem_pop();
        end
        chk({tag, " tx drained"}, int'(tx_empty), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic n;
        logic [7:0] v;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset state
        chk("R12 sda released", int'(sda_line), 1);
        chk("R12 irq high", int'(irq_n), 1);
        chk("R12 tx empty", int'(tx_empty), 1);
        chk("R12 rx not full", int'(rx_full), 0);

        // R10, R3: identifier through the read pointer
        rd_burst(RA_IDENT, 1);
        chk("R10 ident", int'(rbuf[0]), 'hB1);
        // R7: enable reset value
        rd_burst(RA_IMASK, 1);
        chk("R7 mask reset", int'(rbuf[0]), 'h08);

        // R1: foreign and own address
        bus_start(); wbyte({ADDR_HI, 3'b011, 1'b0}, n); bus_stop();
        chk("R1 foreign nack", int'(n), 1);
        chk("R1 line released", int'(sda_line), 1);
        bus_start(); wbyte(DEV_W, n); bus_stop();
        chk("R1 own ack", int'(n), 0);

        // R2: burst write with auto-increment across 0x03 and 0x04
        bus_start(); wbyte(DEV_W, n); wbyte(RA_FCTL, n); wbyte(8'h00, n); wbyte(8'hF5, n); bus_stop();
        rd_burst(RA_FCTL, 2);
        chk("R2 fctl byte", int'(rbuf[0]), 'h00);
        chk("R2 incremented to mask", int'(rbuf[1]), int'(mask_of(8'hF5)));
        // R3: a fresh read starts again at the stored pointer
        rd_raw(1);
        chk("R3 pointer kept", int'(rbuf[0]), 'h00);
        rd_burst(RA_RDPTR, 1);
        chk("R3 pointer reads itself", int'(rbuf[0]), 'h00);
        wr_reg(RA_IMASK, 8'h08);

        // R10: unlisted index ignores writes
        wr_reg(8'h40, 8'h5A);
        rd_burst(8'h40, 1);
        chk("R10 unlisted reads zero", int'(rbuf[0]), 0);

        // R4: fill the transmit queue and overflow by one
        wr_reg(RA_FCTL, {5'b0, FC_ALL});
        bus_start(); wbyte(DEV_W, n); wbyte(RA_TXPORT, n);
        for (int i = 0; i <= DEPTH; i++) begin
            model[i] = 8'(8'h30 + i);
            wbyte(model[i], n);
            chk(i < DEPTH ? "R4 ack while space" : "R4 nack when full", int'(n), i < DEPTH ? 0 : 1);
        end
        bus_stop();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R4 tx order", int'(tx_data), int'(model[i]));
            modem_pop();
        end
        chk("R4 tx empty after drain", int'(tx_empty), 1);
        modem_pop();
        chk("R4 pop on empty ignored", int'(tx_empty), 1);

        // R5: receive queue, overflow push ignored, empty read gives zero
        for (int i = 0; i <= DEPTH; i++) begin
            model[i] = 8'($urandom);
            modem_push(model[i]);
        end
        chk("R5 rx full", int'(rx_full), 1);
        rd_burst(RA_RXPORT, DEPTH + 1);
        for (int i = 0; i < DEPTH; i++) chk("R5 rx order", int'(rbuf[i]), int'(model[i]));
        chk("R5 empty read zero", int'(rbuf[DEPTH]), 0);
        chk("R5 rx not full", int'(rx_full), 0);

        // R6: pointer rewinds keep contents
        wr_reg(RA_FCTL, 8'h05);
        rd_burst(RA_RXPORT, 1);
        chk("R6 code 101 no effect", int'(rbuf[0]), 0);
        wr_reg(RA_FCTL, {5'b0, FC_RX_RD});
        rd_burst(RA_RXPORT, 2);
        chk("R6 rx replay 0", int'(rbuf[0]), int'(model[0]));
        chk("R6 rx replay 1", int'(rbuf[1]), int'(model[1]));
        rd_burst(RA_FCTL, 1);
        chk("R6 fctl readback", int'(rbuf[0]), int'(FC_RX_RD));
        wr_reg(RA_FCTL, {5'b0, FC_ALL});
        bus_start(); wbyte(DEV_W, n); wbyte(RA_TXPORT, n); wbyte(8'hA1, n); wbyte(8'hA2, n); bus_stop();
        chk("R6 tx loaded", int'(tx_empty), 0);
        wr_reg(RA_FCTL, {5'b0, FC_TX_WR});
        chk("R6 tx write rewind", int'(tx_empty), 1);
        bus_start(); wbyte(DEV_W, n); wbyte(RA_TXPORT, n); wbyte(8'hC3, n); wbyte(8'hC4, n); bus_stop();
        modem_pop(); modem_pop();
        chk("R6 tx drained", int'(tx_empty), 1);
        wr_reg(RA_FCTL, {5'b0, FC_TX_RD});
        chk("R6 tx read rewind", int'(tx_empty), 0);
        chk("R6 tx replay", int'(tx_data), 'hC3);
        wr_reg(RA_FCTL, {5'b0, FC_ALL});
        chk("R6 all rewind", int'(tx_empty), 1);

        // R8, R9: sticky flags, clear on read, interrupt gating
        pulse_evt(4'b0001);
        chk("R9 masked event no irq", int'(irq_n), 1);
        rd_burst(RA_ISTAT, 1);
        chk("R8 status set", int'(rbuf[0]), 'h01);
        rd_burst(RA_ISTAT, 1);
        chk("R8 cleared by read", int'(rbuf[0]), 'h00);
        pulse_evt(4'b1000);
        chk("R9 enabled event irq", int'(irq_n), 0);
        rd_burst(RA_ISTAT, 1);
        chk("R8 command flag", int'(rbuf[0]), 'h08);
        chk("R9 irq released", int'(irq_n), 1);
        wr_reg(RA_IMASK, 8'h04);
        pulse_evt(4'b0100);
        chk("R9 new enable irq", int'(irq_n), 0);
        wr_reg(RA_IMASK, 8'h00);
        chk("R9 disable releases", int'(irq_n), 1);
        rd_burst(RA_ISTAT, 1);
        chk("R8 flag kept while masked", int'(rbuf[0]), 'h04);

        // R11: repeated start and stop
        bus_start(); wbyte(DEV_W, n); wbyte(RA_RDPTR, n); wbyte(RA_IDENT, n);
        bus_start(); wbyte(DEV_R, n);
        chk("R11 restart address ack", int'(n), 0);
        rbyte(1'b1, v); bus_stop();
        chk("R11 read after restart", int'(v), 'hB1);
        bus_start(); wbyte(DEV_W, n); bus_stop();
        chk("R11 stop releases", int'(sda_line), 1);

        // Random: enable register round trips and transmit bursts
        for (int it = 0; it < 12; it++) begin
            v = 8'($urandom);
            wr_reg(RA_IMASK, v);
            rd_burst(RA_IMASK, 1);
            chk("R7 random mask", int'(rbuf[0]), int'(mask_of(v)));
            tx_burst_check(1 + int'($urandom % DEPTH), "R4 random");
        end

        finish_run();
    end

endmodule